// File: doc/BRIEF.md
# Microframe Periodic Scheduling Timer

This block keeps time inside each USB frame or microframe. It drives two signals for a descriptor-based DMA engine. A start-of-frame strobe restarts an elapsed-cycle counter. The interval length, in clock cycles, is an input, so the same block serves both frame and microframe timing.

From the elapsed count the block derives two outputs:
- A service select. It gives periodic IN fetching priority for a programmable share at the start of the interval, then hands the rest of the interval to non-periodic traffic.
- A single-cycle notification pulse at a programmable point late in the interval.

Both points are a percentage of the interval length. Integer arithmetic derives them and rounds down.

Periodic priority applies only when scatter/gather DMA is enabled and at least one periodic endpoint is active. Otherwise the select stays on non-periodic fetching, whatever window is programmed.

Top module: `ufrm_sched_timer`

## Requirements
- R1: A start-of-frame strobe sampled at a clock edge sets the elapsed count to 0 for the next cycle. Without a strobe, the count rises by one per clock.
- R2: If the next strobe is late, the elapsed count stops at the interval length and holds there. The notification does not repeat while the count is held.
- R3: The window threshold is floor(L*P/100), where L is the interval length. The window code sets P: 0 gives 25, 1 gives 50, 2 gives 75, and the reserved code 3 gives 25.
- R4: With scatter/gather enabled and a periodic endpoint active, `per_sel_o` is 1 exactly while the elapsed count is below the window threshold. In the same cycle it reacts to changes of those two inputs.
- R5: While `per_ep_act_i` is 0, `per_sel_o` is 0 whatever the window code is.
- R6: While `sg_dma_en_i` is 0, `per_sel_o` is 0 whatever the window code is.
- R7: The notify threshold is floor(L*P/100). The notify code sets P: 0 gives 80, 1 gives 85, 2 gives 90, 3 gives 95.
- R8: `notify_irq_o` is a one-cycle pulse. It rises in the first cycle of an interval in which the elapsed count is at or above the notify threshold, and it does not repeat before the next strobe.
- R9: Both thresholds follow the current interval length and codes with no added delay, including changes made in the middle of an interval.
- R10: Synchronous active-high reset clears the elapsed count and the fired flag. The first cycle after reset behaves as elapsed count 0 in a fresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe |
| intvl_len_i | input | CNT_W | Interval length in clock cycles |
| win_code_i | input | 2 | Periodic window code (0:25%, 1:50%, 2:75%, 3:25%) |
| notify_code_i | input | 2 | Notification point code (0:80%, 1:85%, 2:90%, 3:95%) |
| sg_dma_en_i | input | 1 | Scatter/gather DMA enabled |
| per_ep_act_i | input | 1 | At least one periodic endpoint is active |
| per_sel_o | output | 1 | 1 = fetch periodic IN data, 0 = fetch non-periodic data |
| notify_irq_o | output | 1 | End-of-periodic-interval notification pulse |

## Verification
Both outputs are combinational from the registered elapsed count and fired flag, so a change of enable, activity, code or length shows in the same cycle. A strobe sampled at an edge shows one cycle later, as elapsed count 0. The bench drives inputs on the falling edge and compares both outputs one time unit later against a behavioural model. The model advances only at the rising edge, so every expected value matches the register state in the design. Directed frames also count the high cycles of the select and the index of the notification pulse in each interval, and compare them with the rounded-down percentages.

// File: rtl/ufrm_sched_pkg.sv
package ufrm_sched_pkg;

    localparam int unsigned PCT_W   = 7;
    localparam int unsigned PCT_DIV = 100;
    localparam int unsigned NUM_THR = 2;
    localparam int unsigned THR_WIN = 0;
    localparam int unsigned THR_NOT = 1;

    typedef enum logic [1:0] {
        WIN_QUARTER = 2'd0,
        WIN_HALF    = 2'd1,
        WIN_3QUART  = 2'd2,
        WIN_RSVD    = 2'd3
    } win_code_e;

    typedef enum logic [1:0] {
        NOTE_80 = 2'd0,
        NOTE_85 = 2'd1,
        NOTE_90 = 2'd2,
        NOTE_95 = 2'd3
    } notify_code_e;

    typedef struct packed {
        win_code_e    win;
        notify_code_e note;
    } sched_cfg_t;

    // Reserved window code falls back to the smallest share.
    function automatic logic [PCT_W-1:0] win_pct(input win_code_e c);
        case (c)
            WIN_HALF:   return PCT_W'(50);
            WIN_3QUART: return PCT_W'(75);
            default:    return PCT_W'(25);
        endcase
    endfunction

    function automatic logic [PCT_W-1:0] note_pct(input notify_code_e c);
        case (c)
            NOTE_85: return PCT_W'(85);
            NOTE_90: return PCT_W'(90);
            NOTE_95: return PCT_W'(95);
            default: return PCT_W'(80);
        endcase
    endfunction

endpackage

// File: rtl/ufrm_elapsed_ctr.sv
module ufrm_elapsed_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (sof) begin
            count <= '0;
        end else if (count < limit) begin
            count <= count + 1'b1;
        end else begin
            count <= limit;
        end
    end

    assert_sof_clear_R1: assert property (@(posedge clk) disable iff (rst)
        sof |=> (count == '0));

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!sof && count < limit) |=> (count == $past(count) + 1'b1));

    assert_saturate_R2: assert property (@(posedge clk) disable iff (rst)
        (!sof && count >= limit) |=> (count == $past(limit)));

endmodule

// File: rtl/ufrm_pct_scale.sv
module ufrm_pct_scale
    import ufrm_sched_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] len_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic [CNT_W-1:0] thr_o
);

    localparam int unsigned PROD_W = CNT_W + PCT_W;

    logic [PROD_W-1:0] prod;

    // Integer scaling, rounded toward zero.
    assign prod  = PROD_W'(len_i) * PROD_W'(pct_i);
    assign thr_o = CNT_W'(prod / PROD_W'(PCT_DIV));

endmodule

// File: rtl/ufrm_notify_pulse.sv
module ufrm_notify_pulse #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    output logic             pulse
);

    logic fired;

    assign pulse = !fired && (count >= thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            fired <= 1'b0;
        end else if (sof) begin
            fired <= 1'b0;
        end else if (pulse) begin
            fired <= 1'b1;
        end
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse && !sof) |=> !pulse);

    assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
        sof |=> (pulse == (count >= thr)));

endmodule

// File: rtl/ufrm_sched_timer.sv
module ufrm_sched_timer
    import ufrm_sched_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] intvl_len_i,
    input  logic [1:0]       win_code_i,
    input  logic [1:0]       notify_code_i,
    input  logic             sg_dma_en_i,
    input  logic             per_ep_act_i,
    output logic             per_sel_o,
    output logic             notify_irq_o
);

    sched_cfg_t       cfg;
    logic [CNT_W-1:0] elapsed;
    logic [PCT_W-1:0] pct  [NUM_THR];
    logic [CNT_W-1:0] thr  [NUM_THR];
    logic             prio_ok;

    assign cfg.win  = win_code_e'(win_code_i);
    assign cfg.note = notify_code_e'(notify_code_i);

    assign pct[THR_WIN] = win_pct(cfg.win);
    assign pct[THR_NOT] = note_pct(cfg.note);

    ufrm_elapsed_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .sof   (sof_i),
        .limit (intvl_len_i),
        .count (elapsed)
    );

    for (genvar g = 0; g < NUM_THR; g++) begin : g_scale
        ufrm_pct_scale #(.CNT_W(CNT_W)) u_scale (
            .len_i (intvl_len_i),
            .pct_i (pct[g]),
            .thr_o (thr[g])
        );
    end

    ufrm_notify_pulse #(.CNT_W(CNT_W)) u_note (
        .clk   (clk),
        .rst   (rst),
        .sof   (sof_i),
        .count (elapsed),
        .thr   (thr[THR_NOT]),
        .pulse (notify_irq_o)
    );

    // Periodic priority only in scatter/gather mode with periodic work pending.
    assign prio_ok   = sg_dma_en_i && per_ep_act_i;
    assign per_sel_o = prio_ok && (elapsed < thr[THR_WIN]);

    assert_idle_nonper_R5: assert property (@(posedge clk) disable iff (rst)
        !per_ep_act_i |-> !per_sel_o);

    assert_sg_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !sg_dma_en_i |-> !per_sel_o);

    assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
        thr[THR_WIN] <= intvl_len_i);

    assert_thr_order_R7: assert property (@(posedge clk) disable iff (rst)
        thr[THR_NOT] >= thr[THR_WIN]);

    assert_no_prio_late_R4: assert property (@(posedge clk) disable iff (rst)
        notify_irq_o |-> !per_sel_o);

endmodule

// File: tb/tb_ufrm_sched_timer.sv
module tb_ufrm_sched_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             sof_i;
    logic [CNT_W-1:0] intvl_len_i;
    logic [1:0]       win_code_i;
    logic [1:0]       notify_code_i;
    logic             sg_dma_en_i;
    logic             per_ep_act_i;
    logic             per_sel_o;
    logic             notify_irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ufrm_sched_timer #(.CNT_W(CNT_W)) dut (
        .clk           (clk),
        .rst           (rst),
        .sof_i         (sof_i),
        .intvl_len_i   (intvl_len_i),
        .win_code_i    (win_code_i),
        .notify_code_i (notify_code_i),
        .sg_dma_en_i   (sg_dma_en_i),
        .per_ep_act_i  (per_ep_act_i),
        .per_sel_o     (per_sel_o),
        .notify_irq_o  (notify_irq_o)
    );

    int    checks   = 0;
    int    failures = 0;
    bit    primed   = 0;
    bit    done     = 0;
    string scen     = "R10";

    // Behavioural model state
    int m_el    = 0;
    bit m_fired = 0;
    bit s_sel;
    bit s_irq;

    int win_tab  [4] = '{25, 50, 75, 25};
    int note_tab [4] = '{80, 85, 90, 95};

    function automatic int scale(input int l, input int p);
        return (l * p) / 100;
    endfunction

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%0d exp=%0d", scen, what, got, exp);
        end
    endtask

    // One clock: inputs are already set at the falling edge.
    task automatic tick(input bit s);
        int  wthr;
        int  ethr;
        bit  e_sel;
        bit  e_irq;
        string stag;
        sof_i = s;
        #1;
        wthr  = scale(int'(intvl_len_i), win_tab[win_code_i]);
        ethr  = scale(int'(intvl_len_i), note_tab[notify_code_i]);
        e_sel = sg_dma_en_i && per_ep_act_i && (m_el < wthr);
        e_irq = !m_fired && (m_el >= ethr);
        s_sel = per_sel_o;
        s_irq = notify_irq_o;
        if (primed && !rst) begin
            stag = !sg_dma_en_i ? "R6" : (!per_ep_act_i ? "R5" : "R4");
            check(per_sel_o === e_sel, {"per_sel ", stag}, int'(per_sel_o), int'(e_sel));
            check(notify_irq_o === e_irq, "notify_irq R8", int'(notify_irq_o), int'(e_irq));
        end
        @(posedge clk);
        if (rst) begin
            m_el    = 0;
            m_fired = 0;
        end else begin
            m_fired = s ? 1'b0 : (m_fired | e_irq);
            if (s) m_el = 0;
            else if (m_el < int'(intvl_len_i)) m_el = m_el + 1;
            else m_el = int'(intvl_len_i);
        end
        primed = 1;
        @(negedge clk);
    endtask

    // Strobe, then n cycles; counts select cycles and notify pulses.
    task automatic frame(input int n, output int sel_cnt, output int irq_cnt, output int irq_at);
        sel_cnt = 0;
        irq_cnt = 0;
        irq_at  = -1;
        tick(1'b1);
        for (int i = 0; i < n; i++) begin
            tick(1'b0);
            if (s_sel) sel_cnt++;
            if (s_irq) begin
                irq_cnt++;
                if (irq_at < 0) irq_at = i;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int sc, ic, ia;
        rst = 1'b1; sof_i = 1'b0; intvl_len_i = 16'd40;
        win_code_i = 2'd0; notify_code_i = 2'd0;
        sg_dma_en_i = 1'b1; per_ep_act_i = 1'b1;
        @(negedge clk);
        repeat (3) tick(1'b0);
        rst = 1'b0;

        // R10: first cycle after reset is elapsed 0 of a fresh interval
        scen = "R10";
        tick(1'b0);
        check(s_sel == 1'b1, "per_sel after reset R10", int'(s_sel), 1);
        check(s_irq == 1'b0, "irq after reset R10", int'(s_irq), 0);

        // R3 / R7 / R8: every code pair on a 100-cycle interval
        intvl_len_i = 16'd100;
        for (int c = 0; c < 4; c++) begin
            scen = "R3_R7";
            win_code_i = 2'(c); notify_code_i = 2'(c);
            frame(100, sc, ic, ia);
            check(sc == win_tab[c], "window length R3", sc, win_tab[c]);
            check(ia == note_tab[c], "notify index R7", ia, note_tab[c]);
            check(ic == 1, "single pulse R8", ic, 1);
        end

        // R3 / R7 rounding on an odd length
        scen = "R3_R7_round";
        intvl_len_i = 16'd33; win_code_i = 2'd2; notify_code_i = 2'd3;
        frame(33, sc, ic, ia);
        check(sc == 24, "floor window R3", sc, 24);
        check(ia == 31, "floor notify R7", ia, 31);

        // R5: no periodic endpoint active
        scen = "R5";
        intvl_len_i = 16'd60; win_code_i = 2'd2; notify_code_i = 2'd1;
        per_ep_act_i = 1'b0;
        frame(60, sc, ic, ia);
        check(sc == 0, "no periodic select R5", sc, 0);
        check(ic == 1, "notify still fires R5", ic, 1);

        // R6: scatter/gather disabled
        scen = "R6";
        per_ep_act_i = 1'b1; sg_dma_en_i = 1'b0;
        frame(60, sc, ic, ia);
        check(sc == 0, "no periodic select R6", sc, 0);
        sg_dma_en_i = 1'b1;

        // R2: late strobe, counter holds at the length
        scen = "R2";
        intvl_len_i = 16'd50; win_code_i = 2'd1; notify_code_i = 2'd0;
        frame(120, sc, ic, ia);
        check(sc == 25, "window under saturation R2", sc, 25);
        check(ic == 1, "no repeat at saturation R2", ic, 1);
        check(ia == 40, "notify index R2", ia, 40);

        // R1: early strobe restarts the count
        scen = "R1";
        intvl_len_i = 16'd100; notify_code_i = 2'd0;
        frame(30, sc, ic, ia);
        check(ic == 0, "no notify before threshold R1", ic, 0);
        frame(100, sc, ic, ia);
        check(ia == 80, "restart from zero R1", ia, 80);

        // R9: length and window change in the middle of an interval
        scen = "R9";
        intvl_len_i = 16'd100; win_code_i = 2'd1; notify_code_i = 2'd0;
        sc = 0; ic = 0; ia = -1;
        tick(1'b1);
        for (int i = 0; i < 60; i++) begin
            if (i == 10) intvl_len_i = 16'd40;
            tick(1'b0);
            if (s_sel) sc++;
            if (s_irq) begin ic++; if (ia < 0) ia = i; end
        end
        check(sc == 20, "select after length change R9", sc, 20);
        check(ia == 32, "notify after length change R9", ia, 32);

        // R4: activity toggling mid-interval, same-cycle response
        scen = "R4";
        intvl_len_i = 16'd80; win_code_i = 2'd2;
        tick(1'b1);
        for (int i = 0; i < 80; i++) begin
            per_ep_act_i = (i % 7 != 3);
            sg_dma_en_i  = (i % 11 != 5);
            tick(1'b0);
        end
        per_ep_act_i = 1'b1; sg_dma_en_i = 1'b1;

        // R10: reset in the middle of an interval
        scen = "R10";
        rst = 1'b1;
        tick(1'b0);
        rst = 1'b0;
        tick(1'b0);
        check(s_sel == 1'b1, "select after mid reset R10", int'(s_sel), 1);
        repeat (70) tick(1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule